// File: doc/BRIEF.md
# PLL output rate estimator

This block works out the output frequency of a fractional-N PLL from the values that set it up. It takes three inputs: the reference frequency, the feedback-divider code and a post-divider exponent. The feedback code has a fixed integer part of seven bits. Any bits of the code beyond those seven are fraction bits. The total code width is a static parameter.

The block multiplies the reference frequency by the code to get the oscillator value. It then drops the fraction bits and divides by two raised to the post-divider exponent. Both of these steps round upward, so the reported rate never falls below the true rate.

A caller raises a one-cycle request with the operands on the inputs. One cycle later the result appears together with a done pulse. The result stays on the output until the next request.

Top module: `pll_rate_est`

## Requirements
- R1: The number of fraction bits is the code width minus 7 when the width is above 7, and zero otherwise.
- R2: The oscillator value is the full product of the reference frequency and the code, with no bits lost.
- R3: When there are fraction bits, the oscillator value is shifted right by that count. One is added when any of the shifted-out bits is set.
- R4: The post-divider exponent field holds a value e from 0 to 7, and the divisor is 2^e. All eight values are accepted, including those above 3.
- R5: The final rate is the fraction-stage result divided by 2^e, rounded up. This equals (x + 2^e - 1) / 2^e.
- R6: A request sampled high at a clock edge makes done_o high for the next cycle only. rate_o carries that request's result during the same cycle.
- R7: Without a request, rate_o keeps its value and does not follow changes on the operand inputs.
- R8: While reset is held, and right after it, rate_o is 0 and done_o is 0.
- R9: With a code width of 7 or less, the fraction stage does no rounding. The rate is then the ceiling of ref*code / 2^e.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe; operands are sampled when it is high |
| ref_i | input | REF_W | Reference frequency |
| pcw_i | input | PCW_W | Feedback-divider code: 7 integer bits above the fraction bits |
| pdiv_exp_i | input | EXP_W | Post-divider exponent e (divisor 2^e) |
| rate_o | output | RATE_W | Computed output rate, held between requests |
| done_o | output | 1 | One-cycle pulse when rate_o is updated |

## Verification
Two instances run side by side. One has fourteen code bits, so it has seven fraction bits. The other has seven code bits, so it has none. Both are swept over a grid of operands:
- Reference values include zero, one, small odd numbers and the all-ones maximum.
- Codes include zero, one, exact integer codes, codes just above an integer and all-ones codes.
- Every exponent from 0 to 7 is tried with each of these.

Exact integer codes and exact multiples of the divisor show whether rounding fires when it should not. Codes just above an integer and odd references show whether each of the two ceilings is missing. The all-ones operands show whether the product is truncated. The seven-bit instance shows whether the fraction stage is skipped. A separate pass changes the operands with no request, to show that the output holds.

// File: rtl/rte_pkg.sv
package rte_pkg;
  localparam int unsigned INT_BITS = 7;

  function automatic int unsigned frac_bits(input int unsigned code_w);
    return (code_w > INT_BITS) ? code_w - INT_BITS : 0;
  endfunction
endpackage

// File: rtl/rte_vco_mul.sv
module rte_vco_mul #(
  parameter int unsigned A_W = 32,
  parameter int unsigned B_W = 21,
  parameter int unsigned P_W = 64
) (
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic [P_W-1:0] p_o
);
  // Full-width product: both operands widened before multiply (R2)
  assign p_o = P_W'(a_i) * P_W'(b_i);

  always_comb begin
    if (a_i != '0 && b_i != '0) begin
      p_full_r2: assert (p_o >= P_W'(a_i) && p_o >= P_W'(b_i))
        else $error("product smaller than an operand");
    end
  end
endmodule

// File: rtl/rte_frac_ceil.sv
module rte_frac_ceil #(
  parameter int unsigned DW     = 64,
  parameter int unsigned FRAC_W = 14
) (
  input  logic [DW-1:0] vco_i,
  output logic [DW-1:0] res_o
);
  generate
    if (FRAC_W == 0) begin : g_nofrac
      // No fraction bits: pass through, no rounding (R9)
      assign res_o = vco_i;
    end else begin : g_frac
      logic sticky;
      logic [DW:0] back;
      assign sticky = |vco_i[FRAC_W-1:0];
      assign res_o  = (vco_i >> FRAC_W) + DW'(sticky);
      assign back   = {1'b0, res_o} << FRAC_W;

      always_comb begin
        p_ceil_lo_r3: assert (back >= {1'b0, vco_i})
          else $error("fraction stage rounded down");
        p_ceil_hi_r3: assert (back - {1'b0, vco_i} < ((DW+1)'(1) << FRAC_W))
          else $error("fraction stage rounded up too far");
      end
    end
  endgenerate
endmodule

// File: rtl/rte_pdiv_ceil.sv
module rte_pdiv_ceil #(
  parameter int unsigned DW    = 64,
  parameter int unsigned EXP_W = 3
) (
  input  logic [DW-1:0]    val_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic [DW-1:0]    res_o
);
  logic [DW-1:0] mask;
  logic          sticky;
  logic [DW:0]   back;

  // Divisor 2^e for every e (R4); shifted-out bits round up (R5)
  assign mask   = (DW'(1) << exp_i) - DW'(1);
  assign sticky = |(val_i & mask);
  assign res_o  = (val_i >> exp_i) + DW'(sticky);
  assign back   = {1'b0, res_o} << exp_i;

  always_comb begin
    p_div_lo_r5: assert (back >= {1'b0, val_i})
      else $error("post-divide rounded down");
    p_div_hi_r5: assert (back - {1'b0, val_i} < ((DW+1)'(1) << exp_i))
      else $error("post-divide rounded up too far");
  end
endmodule

// File: rtl/pll_rate_est.sv
module pll_rate_est #(
  parameter int unsigned REF_W  = 32,
  parameter int unsigned PCW_W  = 21,
  parameter int unsigned EXP_W  = 3,
  parameter int unsigned RATE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [REF_W-1:0]  ref_i,
  input  logic [PCW_W-1:0]  pcw_i,
  input  logic [EXP_W-1:0]  pdiv_exp_i,
  output logic [RATE_W-1:0] rate_o,
  output logic              done_o
);
  import rte_pkg::*;

  localparam int unsigned FRAC_W = frac_bits(PCW_W);

  // Reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  logic [RATE_W-1:0] vco, frac_res, div_res;

  rte_vco_mul #(.A_W(REF_W), .B_W(PCW_W), .P_W(RATE_W)) u_mul (
    .a_i(ref_i), .b_i(pcw_i), .p_o(vco)
  );

  rte_frac_ceil #(.DW(RATE_W), .FRAC_W(FRAC_W)) u_frac (
    .vco_i(vco), .res_o(frac_res)
  );

  rte_pdiv_ceil #(.DW(RATE_W), .EXP_W(EXP_W)) u_pdiv (
    .val_i(frac_res), .exp_i(pdiv_exp_i), .res_o(div_res)
  );

  // Next state
  logic [RATE_W-1:0] rate_d, rate_q;
  logic              done_d, done_q;
  logic              rate_en;

  always_comb begin
    rate_en = req_i;
    rate_d  = div_res;
    done_d  = req_i;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rate_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (rate_en) rate_q <= rate_d;
    end
  end

  assign rate_o = rate_q;
  assign done_o = done_q;

  p_done_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_q)
    !req_i |=> !done_o);
  p_done_follows_req_r6: assert property (@(posedge clk) disable iff (!rst_q)
    req_i |=> done_o);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_q)
    !req_i |=> $stable(rate_o));
  p_reset_val_r8: assert property (@(posedge clk)
    !rst_q |-> (rate_o == '0 && !done_o));
endmodule

// File: tb/sim_pll_rate_est.sv
`timescale 1ns/1ps
module sim_pll_rate_est;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [31:0] refv;
  logic [13:0] pcw0;
  logic [6:0]  pcw1;
  logic [2:0]  ex;
  logic [63:0] rate0, rate1;
  logic        done0, done1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // Instance with 7 fraction bits
  pll_rate_est #(.REF_W(32), .PCW_W(14), .EXP_W(3), .RATE_W(64)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .ref_i(refv), .pcw_i(pcw0),
    .pdiv_exp_i(ex), .rate_o(rate0), .done_o(done0)
  );
  // Instance with no fraction bits (R9)
  pll_rate_est #(.REF_W(32), .PCW_W(7), .EXP_W(3), .RATE_W(64)) u1 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .ref_i(refv), .pcw_i(pcw1),
    .pdiv_exp_i(ex), .rate_o(rate1), .done_o(done1)
  );

  function automatic logic [63:0] model(input logic [31:0] r, input logic [31:0] p,
                                        input int f, input int e);
    logic [127:0] v, q, d;
    v = 128'(r) * 128'(p);
    q = v / (128'(1) << f);
    if (v % (128'(1) << f) != 0) q = q + 1;
    d = 128'(1) << e;
    return 64'((q + d - 1) / d);
  endfunction

  task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [31:0] r, input logic [13:0] p, input logic [2:0] e);
    @(negedge clk);
    refv = r; pcw0 = p; pcw1 = p[6:0]; ex = e; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    refv = ~r; pcw0 = ~p; pcw1 = ~p[6:0]; ex = ~e;
    chk64("R6 done u0", 64'(done0), 64'd1);
    chk64("R6 done u1", 64'(done1), 64'd1);
    // R1 R2 R3 R4 R5: 7 fraction bits; R9: none
    chk64("R3/R5 rate u0", rate0, model(r, 32'(p), 7, int'(e)));
    chk64("R9/R5 rate u1", rate1, model(r, 32'(p[6:0]), 0, int'(e)));
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] refs [6];
    logic [13:0] codes [7];
    logic [63:0] held0, held1;
    refs[0] = 32'd0; refs[1] = 32'd1; refs[2] = 32'd3;
    refs[3] = 32'd26000000; refs[4] = 32'd12345677; refs[5] = 32'hFFFF_FFFF;
    codes[0] = 14'd0; codes[1] = 14'd1; codes[2] = 14'h0080; codes[3] = 14'h0081;
    codes[4] = 14'h3F80; codes[5] = 14'h3FFF; codes[6] = 14'h1A3B;

    rst_n = 1'b0; req = 1'b0; refv = '0; pcw0 = '0; pcw1 = '0; ex = '0;
    repeat (3) @(negedge clk);
    chk64("R8 rate in reset", rate0 | rate1, 64'd0);
    chk64("R8 done in reset", 64'(done0 | done1), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk64("R8 rate after reset", rate0 | rate1, 64'd0);
    chk64("R8 done after reset", 64'(done0 | done1), 64'd0);

    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 7; j++)
        for (int k = 0; k < 8; k++)
          run_req(refs[i], codes[j], 3'(k));

    // R6: done is a single-cycle pulse
    run_req(32'd999, 14'h2345, 3'd2);
    @(negedge clk);
    chk64("R6 done falls u0", 64'(done0), 64'd0);
    chk64("R6 done falls u1", 64'(done1), 64'd0);

    // R7: operand changes without a request are ignored
    run_req(32'd26000000, 14'h1ABC, 3'd1);
    held0 = model(32'd26000000, 32'h1ABC, 7, 1);
    held1 = model(32'd26000000, 32'h3C, 0, 1);
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      refv = 32'h1234_5678 * (n + 1); pcw0 = 14'(n * 977); pcw1 = 7'(n * 13); ex = 3'(n);
      @(negedge clk);
      chk64("R7 hold u0", rate0, held0);
      chk64("R7 hold u1", rate1, held1);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule